// File: doc/BRIEF.md
# Single-Precision DSP ALU with Guard Bit and Saturation

This block is the single-step arithmetic and logic unit of a DSP core. Each cycle it may accept two 16-bit operands, taken from the register file, together with an operation code, a saturation enable and a carry input. A front stage conditions the operands. It sign-extends them by one guard bit for arithmetic, inverts the second operand for subtraction, picks the carry-in, and masks operands for the logic and shift paths. One of three kernels then does the work: a 17-bit adder, a bitwise logic unit or a barrel shifter.

A back stage optionally clamps an arithmetic result that overflowed. It also derives the carry, sign and zero flags. Result and flags are registered. They appear on the clock edge that samples the issue strobe and hold until the next issued operation.

Top module: `alu16_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0x0000 and `flag_c`, `flag_s` and `flag_z` become 0 on that edge.
- R2: When `issue` is high at a rising edge, result and flags for the inputs present then are visible after that edge. When `issue` is low, result and flags keep their values.
- R3: Opcodes 0 (add A+B), 1 (subtract A-B) and 2 (add A+B+`carry_in`) are computed on 17 bits with one guard bit. Without saturation the low 16 bits are returned, so a signed overflow wraps.
- R4: With `sat_en` high, an arithmetic result whose two top guard-sum bits differ is clamped to 0x7FFF on positive overflow and to 0x8000 on negative overflow.
- R5: For opcodes 0 and 2, `flag_c` is the unsigned carry out of bit 15. For opcode 1, it is 1 when no borrow occurs, that is A >= B unsigned. Saturation does not change it.
- R6: Opcodes 4 (A AND B), 5 (A OR B), 6 (A XOR B) and 7 (NOT A, B ignored) give the bitwise result.
- R7: Opcodes 8 (logical left), 9 (logical right) and 10 (arithmetic right, sign bit copied in) shift A by B[3:0]. B[15:4] is ignored.
- R8: Opcodes 11 (rotate left) and 12 (rotate right) rotate A by B[3:0] within 16 bits. An amount of 0 leaves A unchanged.
- R9: Logic, shift and rotate operations never saturate, even with `sat_en` high, and they leave `flag_c` at 0.
- R10: `flag_s` equals bit 15 of the final registered result. `flag_z` is 1 exactly when the final 16-bit result is zero.
- R11: Unused opcodes 3, 13, 14 and 15 give result 0x0000 with `flag_c` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation strobe; result updates on this edge |
| op | input | 4 | Operation code |
| sat_en | input | 1 | Enable saturation of arithmetic results |
| carry_in | input | 1 | Carry input for add-with-carry |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B (also the shift amount source) |
| result | output | 16 | Registered result |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
The properties assume that `op`, `opa`, `opb`, `sat_en` and `carry_in` carry known values at every edge where `issue` is high. The sign-preservation property also assumes that the operands it sees on a saturating add are the ones the design registered on that same edge. The stimulus drives every input only on the falling clock edge and never leaves an input undefined after reset. It walks a fixed vector table that includes the overflow boundaries 0x7FFF and 0x8000, shift amounts with high bits set in B, and an unused opcode.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ADC = 4'd2,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_SLL = 4'd8,
        OP_SRL = 4'd9,
        OP_SRA = 4'd10,
        OP_ROL = 4'd11,
        OP_ROR = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        PATH_ARITH,
        PATH_LOGIC,
        PATH_SHIFT,
        PATH_NONE
    } path_e;

    typedef enum logic [1:0] {
        LF_AND,
        LF_OR,
        LF_XOR
    } logic_fn_e;

    typedef enum logic [2:0] {
        SH_PASS,
        SH_SLL,
        SH_SRL,
        SH_SRA,
        SH_ROL,
        SH_ROR
    } sh_mode_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
    } flags_t;

    function automatic path_e path_of(logic [3:0] op);
        case (op)
            OP_ADD, OP_SUB, OP_ADC:                 return PATH_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT:          return PATH_LOGIC;
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR: return PATH_SHIFT;
            default:                                return PATH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/alu16_pre.sv
module alu16_pre
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [3:0]         op,
    input  logic               carry_in,
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    output path_e              path,
    output logic [W:0]         ga,
    output logic [W:0]         gb,
    output logic               cin,
    output logic [W-1:0]       la,
    output logic [W-1:0]       lb,
    output logic_fn_e          lfn,
    output logic [W-1:0]       sa,
    output logic [$clog2(W)-1:0] amt,
    output sh_mode_e           smode
);
    localparam int SW = $clog2(W);

    logic [W:0] ext_a;
    logic [W:0] ext_b;

    assign ext_a = {opa[W-1], opa};
    assign ext_b = {opb[W-1], opb};
    assign path  = path_of(op);

    // Operand masking: every kernel sees zeros unless it is selected.
    always_comb begin
        ga    = '0;
        gb    = '0;
        cin   = 1'b0;
        la    = '0;
        lb    = '0;
        lfn   = LF_AND;
        sa    = '0;
        amt   = '0;
        smode = SH_PASS;
        case (op)
            OP_ADD: begin
                ga = ext_a;
                gb = ext_b;
            end
            OP_SUB: begin
                ga  = ext_a;
                gb  = ~ext_b;
                cin = 1'b1;
            end
            OP_ADC: begin
                ga  = ext_a;
                gb  = ext_b;
                cin = carry_in;
            end
            OP_AND: begin
                la  = opa;
                lb  = opb;
                lfn = LF_AND;
            end
            OP_OR: begin
                la  = opa;
                lb  = opb;
                lfn = LF_OR;
            end
            OP_XOR: begin
                la  = opa;
                lb  = opb;
                lfn = LF_XOR;
            end
            OP_NOT: begin
                la  = opa;
                lb  = '1;
                lfn = LF_XOR;
            end
            OP_SLL: begin
                sa    = opa;
                amt   = opb[SW-1:0];
                smode = SH_SLL;
            end
            OP_SRL: begin
                sa    = opa;
                amt   = opb[SW-1:0];
                smode = SH_SRL;
            end
            OP_SRA: begin
                sa    = opa;
                amt   = opb[SW-1:0];
                smode = SH_SRA;
            end
            OP_ROL: begin
                sa    = opa;
                amt   = opb[SW-1:0];
                smode = SH_ROL;
            end
            OP_ROR: begin
                sa    = opa;
                amt   = opb[SW-1:0];
                smode = SH_ROR;
            end
            default: begin
                ga = '0;
            end
        endcase
    end
endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W:0] ga,
    input  logic [W:0] gb,
    input  logic       cin,
    output logic [W:0] sum,
    output logic       cout
);
    logic [W:0] cin_ext;
    logic [W:0] low_sum;

    assign cin_ext = {{W{1'b0}}, cin};
    // Guarded signed sum over W+1 bits.
    assign sum     = ga + gb + cin_ext;
    // Unsigned carry out of the W-bit field.
    assign low_sum = {1'b0, ga[W-1:0]} + {1'b0, gb[W-1:0]} + cin_ext;
    assign cout    = low_sum[W];
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] la,
    input  logic [W-1:0] lb,
    input  logic_fn_e    lfn,
    output logic [W-1:0] y
);
    always_comb begin
        case (lfn)
            LF_AND:  y = la & lb;
            LF_OR:   y = la | lb;
            LF_XOR:  y = la ^ lb;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]         sa,
    input  logic [$clog2(W)-1:0] amt,
    input  sh_mode_e             smode,
    output logic [W-1:0]         y
);
    localparam int SW = $clog2(W);

    logic [W-1:0] st [SW+1];

    assign st[0] = sa;

    // Logarithmic barrel: stage i moves by 2**i when amt[i] is set.
    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int K = 1 << i;
        logic [W-1:0] moved;
        always_comb begin
            case (smode)
                SH_SLL:  moved = st[i] << K;
                SH_SRL:  moved = st[i] >> K;
                SH_SRA:  moved = $signed(st[i]) >>> K;
                SH_ROL:  moved = (st[i] << K) | (st[i] >> (W - K));
                SH_ROR:  moved = (st[i] >> K) | (st[i] << (W - K));
                default: moved = st[i];
            endcase
        end
        assign st[i+1] = amt[i] ? moved : st[i];
    end

    assign y = st[SW];
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         issue,
    input  logic [3:0]   op,
    input  logic         sat_en,
    input  logic         carry_in,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic         flag_c,
    output logic         flag_s,
    output logic         flag_z
);
    localparam int SW = $clog2(W);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    path_e           path;
    logic [W:0]      ga, gb, sum;
    logic            cin, cout;
    logic [W-1:0]    la, lb, sa, logic_y, shift_y;
    logic_fn_e       lfn;
    logic [SW-1:0]   amt;
    sh_mode_e        smode;

    logic [W-1:0]    nxt_res;
    flags_t          nxt_flags;
    logic [W-1:0]    res_q;
    flags_t          flags_q;

    alu16_pre #(.W(W)) u_pre (
        .op(op), .carry_in(carry_in), .opa(opa), .opb(opb),
        .path(path), .ga(ga), .gb(gb), .cin(cin),
        .la(la), .lb(lb), .lfn(lfn), .sa(sa), .amt(amt), .smode(smode)
    );

    alu16_arith #(.W(W)) u_arith (
        .ga(ga), .gb(gb), .cin(cin), .sum(sum), .cout(cout)
    );

    alu16_logic #(.W(W)) u_logic (
        .la(la), .lb(lb), .lfn(lfn), .y(logic_y)
    );

    alu16_shift #(.W(W)) u_shift (
        .sa(sa), .amt(amt), .smode(smode), .y(shift_y)
    );

    // Post-processing: saturation and flag generation.
    always_comb begin
        nxt_res     = '0;
        nxt_flags.c = 1'b0;
        case (path)
            PATH_ARITH: begin
                if (sat_en && (sum[W] != sum[W-1]))
                    nxt_res = sum[W] ? MIN_NEG : MAX_POS;
                else
                    nxt_res = sum[W-1:0];
                nxt_flags.c = cout;
            end
            PATH_LOGIC: nxt_res = logic_y;
            PATH_SHIFT: nxt_res = shift_y;
            default:    nxt_res = '0;
        endcase
        nxt_flags.s = nxt_res[W-1];
        nxt_flags.z = (nxt_res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (issue) begin
            res_q   <= nxt_res;
            flags_q <= nxt_flags;
        end
    end

    assign result = res_q;
    assign flag_c = flags_q.c;
    assign flag_s = flags_q.s;
    assign flag_z = flags_q.z;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         issue,
    input logic [3:0]   op,
    input logic         sat_en,
    input logic         carry_in,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] result,
    input logic         flag_c,
    input logic         flag_s,
    input logic         flag_z
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (result == '0) && !flag_c && !flag_s && !flag_z);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(result) && $stable(flag_c) && $stable(flag_s) && $stable(flag_z));

    assert_sat_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (issue && sat_en && op == 4'd0 && opa[W-1] == opb[W-1])
        |=> result[W-1] == $past(opa[W-1]));

    assert_and_result_R6: assert property (@(posedge clk) disable iff (rst)
        (issue && op == 4'd4) |=> result == ($past(opa) & $past(opb)));

    assert_no_carry_R9: assert property (@(posedge clk) disable iff (rst)
        (issue && op >= 4'd4) |=> !flag_c);

    assert_sign_flag_R10: assert property (@(posedge clk) disable iff (rst)
        issue |=> flag_s == result[W-1]);

    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (rst)
        issue |=> flag_z == (result == '0));
endmodule

bind alu16_core alu16_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu16_core.sv
`timescale 1ns/1ps
module sim_alu16_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        sat_en = 1'b0;
    logic        carry_in = 1'b0;
    logic [15:0] opa = 16'h0;
    logic [15:0] opb = 16'h0;
    logic [15:0] result;
    logic        flag_c, flag_s, flag_z;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    alu16_core u0 (
        .clk(clk), .rst(rst), .issue(issue), .op(op), .sat_en(sat_en),
        .carry_in(carry_in), .opa(opa), .opb(opb),
        .result(result), .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z)
    );

    // {op, sat, cin, a, b, expected result, expected carry}
    localparam int NV = 23;
    localparam logic [54:0] VECS [NV] = '{
        {4'd0,  1'b0, 1'b0, 16'h1234, 16'h1111, 16'h2345, 1'b0},
        {4'd0,  1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0},
        {4'd0,  1'b1, 1'b0, 16'h7FFF, 16'h0001, 16'h7FFF, 1'b0},
        {4'd0,  1'b1, 1'b0, 16'h8000, 16'h8000, 16'h8000, 1'b1},
        {4'd0,  1'b0, 1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1},
        {4'd1,  1'b0, 1'b0, 16'h0005, 16'h0003, 16'h0002, 1'b1},
        {4'd1,  1'b0, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 1'b0},
        {4'd1,  1'b1, 1'b0, 16'h8000, 16'h0001, 16'h8000, 1'b1},
        {4'd1,  1'b0, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b1},
        {4'd2,  1'b0, 1'b1, 16'h00FF, 16'h0001, 16'h0101, 1'b0},
        {4'd2,  1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 1'b1},
        {4'd4,  1'b1, 1'b1, 16'hF0F0, 16'hFF00, 16'hF000, 1'b0},
        {4'd5,  1'b0, 1'b0, 16'hF0F0, 16'h0F00, 16'hFFF0, 1'b0},
        {4'd6,  1'b0, 1'b0, 16'hAAAA, 16'hFFFF, 16'h5555, 1'b0},
        {4'd7,  1'b0, 1'b0, 16'h00FF, 16'h1234, 16'hFF00, 1'b0},
        {4'd8,  1'b1, 1'b0, 16'h4001, 16'h0001, 16'h8002, 1'b0},
        {4'd9,  1'b0, 1'b0, 16'h8000, 16'h000F, 16'h0001, 1'b0},
        {4'd10, 1'b0, 1'b0, 16'h8000, 16'h0004, 16'hF800, 1'b0},
        {4'd10, 1'b0, 1'b0, 16'h4000, 16'h0014, 16'h0400, 1'b0},
        {4'd11, 1'b0, 1'b0, 16'h8001, 16'h0001, 16'h0003, 1'b0},
        {4'd12, 1'b0, 1'b0, 16'h8001, 16'h0004, 16'h1800, 1'b0},
        {4'd11, 1'b0, 1'b0, 16'h1234, 16'h0000, 16'h1234, 1'b0},
        {4'd13, 1'b0, 1'b1, 16'h1234, 16'h5678, 16'h0000, 1'b0}
    };

    function automatic string tag_of(logic [3:0] o, logic s);
        if (o <= 4'd2) return s ? "R4" : "R3";
        if (o <= 4'd7 && o >= 4'd4) return "R6";
        if (o >= 4'd8 && o <= 4'd10) return "R7";
        if (o == 4'd11 || o == 4'd12) return "R8";
        return "R11";
    endfunction

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", {result, flag_c, flag_s, flag_z}, 19'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [54:0] v;
            logic [15:0] er;
            v = VECS[i];
            @(negedge clk);
            op = v[54:51]; sat_en = v[50]; carry_in = v[49];
            opa = v[48:33]; opb = v[32:17];
            issue = 1'b1;
            er = v[16:1];
            @(negedge clk);
            issue = 1'b0;
            // R2: result visible after the issuing edge
            check(tag_of(v[54:51], v[50]), {3'b0, result}, {3'b0, er});
            // R5 carry / R9 no carry for logic+shift / R10 sign and zero
            check((v[54:51] >= 4'd4) ? "R9 flags" : "R5 R10 flags",
                  {16'h0, flag_c, flag_s, flag_z},
                  {16'h0, v[0], er[15], (er == 16'h0)});
        end

        // R2: hold when issue is low
        @(negedge clk);
        op = 4'd0; sat_en = 1'b0; opa = 16'h0101; opb = 16'h0202; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        held = result;
        check("R2 issued", {3'b0, held}, {3'b0, 16'h0303});
        op = 4'd7; opa = 16'h0000;
        repeat (2) @(negedge clk);
        check("R2 hold", {result, flag_c, flag_s, flag_z}, {16'h0303, 3'b000});

        // R3: negative plus negative without saturation wraps
        op = 4'd0; opa = 16'hFFFF; opb = 16'hFFFF; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check("R3 wrap", {result, flag_c, flag_s, flag_z}, {16'hFFFE, 3'b110});

        // R1: reset mid-run clears registers
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", {result, flag_c, flag_s, flag_z}, 19'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule